// File: doc/BRIEF.md
# System Clock Control Unit

This block is the register file that software uses to set up the chip's clocks. A 32-bit read/write port reaches its registers. From the two clock-configuration words it works out a system-clock divide factor and keeps it on a registered output. When software brings the PLL out of power-down, the block latches an interrupt event. Behind that event sits a maskable interrupt line. A read-only word gives the PLL setting that goes with the selected crystal. It is taken from one of two tables, and the device-class input chooses the table.

The block also holds the brown-out control, LDO control and reset-cause words, plus three groups of clock-gating words: run, sleep and deep sleep. Identification words are read-only and are fixed by parameters. The block does not generate clocks, does not model the PLL itself and does not reset peripherals.

Top module: `sysclk_ctl`

## Requirements
- R1: A write to the clock word at 0x060 that takes its bit 13 from 1 to 0 sets bit 6 of the raw status at 0x050. On the newer class (`dev_class_i`=1), a write to the second clock word at 0x070 that takes its bit 13 from 1 to 0 does the same. A write that leaves bit 13 at 0 sets nothing.
- R2: `clk_scale_o` equals 5×(word070[28:23]+1) when word070 bit 31 is 1, and 5×(word060[26:23]+1) otherwise. It changes at the second rising edge after the write edge.
- R3: A read of 0x064 returns entry word060[9:6] of the table for the current class. Entry i of the default table for class c is 0xA000 + 0x1000·c + 0x11·i.
- R4: On the older class (`dev_class_i`=0), word070 reads 0, ignores writes, never raises the lock event and never selects the scale. On the newer class it resets to 0x07802810.
- R5: The mask at 0x054 keeps 7 bits. A read of 0x058 returns raw AND mask. A write to 0x058 clears every raw bit that is written as 1 and leaves the others.
- R6: `irq_o` is 1 exactly when raw AND mask is non-zero.
- R7: 0x030 keeps 16 bits, 0x034 keeps 5 bits and 0x05C keeps 6 bits. Writes to the raw status at 0x050 are ignored.
- R8: Identification words at 0x000, 0x004, 0x008, 0x010, 0x014, 0x018 and 0x01C return parameter word n (default 0xD1D00000+n) for n = 0..6 and ignore writes. Unmapped or misaligned offsets read 0, and writes to them change nothing.
- R9: The nine gating words at 0x100, 0x104, 0x108, 0x110, 0x114, 0x118, 0x120, 0x124 and 0x128 hold full 32-bit values and reset to 0.
- R10: After reset, word060 = 0x078E3AC0, mask = 0, raw = 0, `irq_o` = 0 and `clk_scale_o` = 80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_class_i | input | 1 | Device class: 0 older, 1 newer |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_o | output | 1 | Level interrupt |
| clk_scale_o | output | SCALE_W | System clock divide factor |

## Verification
Wrong internal state shows up at the ports in different ways.

- **Clock-field decode.** A wrong decode or a wrong choice of register shows on `clk_scale_o` two edges after the write. The bench sweeps every field value on both clock words, so it shows up at once.
- **Lock detection.** A missed or spurious power-up event shows on the raw status read and on `irq_o` in the cycle after the write.
- **Masks and holes.** A dropped write mask, a clear that is too wide or a decode hole that is wrongly mapped shows on the very next read of that offset.
- **Table indexing.** Bad indexing shows directly in the swept PLL reads for both classes.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

   localparam int IRQ_W      = 7;
   localparam int LOCK_BIT   = 6;
   localparam int PD_BIT     = 13;
   localparam int ID_N       = 7;
   localparam int XTAL_W     = 4;
   localparam int SCALE_MINW = 9;

   // word offsets (byte offset >> 2)
   localparam logic [9:0] W_BOR    = 10'h00C;
   localparam logic [9:0] W_LDO    = 10'h00D;
   localparam logic [9:0] W_RAW    = 10'h014;
   localparam logic [9:0] W_MASK   = 10'h015;
   localparam logic [9:0] W_MISC   = 10'h016;
   localparam logic [9:0] W_RCAUSE = 10'h017;
   localparam logic [9:0] W_CLK1   = 10'h018;
   localparam logic [9:0] W_PLL    = 10'h019;
   localparam logic [9:0] W_CLK2   = 10'h01C;
   localparam logic [9:0] W_GATE   = 10'h040;

   localparam logic [31:0] CLK2_RST = 32'h0780_2810;

   typedef logic [15:0][31:0]     pll_tbl_t;
   typedef logic [ID_N-1:0][31:0] id_tbl_t;

   function automatic pll_tbl_t default_tbl(input logic cls);
      pll_tbl_t t;
      for (int i = 0; i < 16; i++)
         t[i] = 32'h0000_A000 + (cls ? 32'h0000_1000 : 32'h0) + 32'(i) * 32'h11;
      return t;
   endfunction

   function automatic id_tbl_t default_ids();
      id_tbl_t t;
      for (int i = 0; i < ID_N; i++)
         t[i] = 32'hD1D0_0000 + 32'(i);
      return t;
   endfunction

   function automatic logic [8:0] scale_of(input logic       use2,
                                           input logic [3:0] f1,
                                           input logic [5:0] f2);
      logic [8:0] n;
      n = use2 ? (9'(f2) + 9'd1) : (9'(f1) + 9'd1);
      return n * 9'd5;
   endfunction

endpackage

// File: rtl/sysclk_irq.sv
module sysclk_irq
   import sysclk_pkg::*;
#(
   parameter int N   = IRQ_W,
   parameter int BIT = LOCK_BIT
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         lock_evt,
   input  logic         mask_we,
   input  logic         clr_we,
   input  logic [N-1:0] wdata,
   output logic [N-1:0] raw_q,
   output logic [N-1:0] mask_q,
   output logic         irq
);
   generate
      if (BIT >= N) begin : g_bad_bit
         $error("sysclk_irq: event bit outside status width");
      end
   endgenerate

   logic [N-1:0] clr_vec, set_vec;

   assign clr_vec = clr_we ? wdata : '0;
   assign set_vec = N'(lock_evt) << BIT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q  <= '0;
         mask_q <= '0;
      end else begin
         raw_q <= (raw_q & ~clr_vec) | set_vec;
         if (mask_we) mask_q <= wdata;
      end
   end

   assign irq = |(raw_q & mask_q);
endmodule

// File: rtl/sysclk_scale.sv
module sysclk_scale
   import sysclk_pkg::*;
#(
   parameter int          SCALE_W = SCALE_MINW,
   parameter logic [8:0]  RST_VAL = 9'd80
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               use2,
   input  logic [3:0]         fld1,
   input  logic [5:0]         fld2,
   output logic [SCALE_W-1:0] scale_q
);
   generate
      if (SCALE_W < SCALE_MINW) begin : g_bad_w
         $error("sysclk_scale: SCALE_W too narrow for 5*64");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scale_q <= SCALE_W'(RST_VAL);
      else        scale_q <= SCALE_W'(scale_of(use2, fld1, fld2));
   end
endmodule

// File: rtl/sysclk_pll_lut.sv
module sysclk_pll_lut
   import sysclk_pkg::*;
#(
   parameter pll_tbl_t TBL_OLD = default_tbl(1'b0),
   parameter pll_tbl_t TBL_NEW = default_tbl(1'b1)
) (
   input  logic              cls,
   input  logic [XTAL_W-1:0] idx,
   output logic [31:0]       word
);
   assign word = cls ? TBL_NEW[idx] : TBL_OLD[idx];
endmodule

// File: rtl/sysclk_gate_bank.sv
module sysclk_gate_bank #(
   parameter int GROUPS = 3,
   parameter int PER    = 3,
   localparam int N      = GROUPS * PER,
   localparam int SLOT_W = $clog2(N)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [SLOT_W-1:0]    slot,
   input  logic [31:0]          wdata,
   output logic [N-1:0][31:0]   regs_q
);
   generate
      if (GROUPS < 1 || GROUPS > 4 || PER < 1 || PER > 4 || N < 2) begin : g_bad_shape
         $error("sysclk_gate_bank: groups and words per group must be 1..4");
      end
      for (genvar g = 0; g < GROUPS; g++) begin : g_grp
         for (genvar p = 0; p < PER; p++) begin : g_word
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  regs_q[g*PER+p] <= '0;
               else if (we && slot == SLOT_W'(g*PER+p))
                  regs_q[g*PER+p] <= wdata;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/sysclk_ctl.sv
module sysclk_ctl
   import sysclk_pkg::*;
#(
   parameter int          ADDR_W      = 12,
   parameter int          SCALE_W     = 9,
   parameter int          GATE_GROUPS = 3,
   parameter int          GATE_PER    = 3,
   parameter logic [31:0] CLK1_RST    = 32'h078E_3AC0,
   parameter logic [5:0]  RCAUSE_RST  = 6'h00,
   parameter id_tbl_t     ID_WORDS    = default_ids(),
   parameter pll_tbl_t    TBL_OLD     = default_tbl(1'b0),
   parameter pll_tbl_t    TBL_NEW     = default_tbl(1'b1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dev_class_i,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wen,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               irq_o,
   output logic [SCALE_W-1:0] clk_scale_o
);
   localparam int WA_W     = ADDR_W - 2;
   localparam int GATE_N   = GATE_GROUPS * GATE_PER;
   localparam int SLOT_W   = $clog2(GATE_N);
   localparam logic [8:0] SCALE_RST = scale_of(CLK2_RST[31], CLK1_RST[26:23], CLK2_RST[28:23]);

   generate
      if (ADDR_W < 9) begin : g_bad_addr
         $error("sysclk_ctl: ADDR_W must cover offset 0x128");
      end
      if (CLK2_RST[31] || CLK1_RST[31]) begin : g_bad_rst
         $error("sysclk_ctl: reset words must not select the second clock word");
      end
   endgenerate

   logic [WA_W-1:0] word;
   logic            aligned;
   logic            wr;

   assign word    = bus_addr[ADDR_W-1:2];
   assign aligned = (bus_addr[1:0] == 2'b00);
   assign wr      = bus_wen && aligned;

   function automatic logic at(input logic [WA_W-1:0] w, input logic [9:0] k);
      return w == WA_W'(k);
   endfunction

   // ---------------- plain registers ----------------
   logic [15:0] bor_q;
   logic [4:0]  ldo_q;
   logic [5:0]  rcause_q;
   logic [31:0] clk1_q, clk2_q, clk2_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bor_q    <= '0;
         ldo_q    <= '0;
         rcause_q <= RCAUSE_RST;
         clk1_q   <= CLK1_RST;
         clk2_q   <= CLK2_RST;
      end else if (wr) begin
         if (at(word, W_BOR))              bor_q    <= bus_wdata[15:0];
         if (at(word, W_LDO))              ldo_q    <= bus_wdata[4:0];
         if (at(word, W_RCAUSE))           rcause_q <= bus_wdata[5:0];
         if (at(word, W_CLK1))             clk1_q   <= bus_wdata;
         if (at(word, W_CLK2) && dev_class_i) clk2_q <= bus_wdata;
      end
   end

   assign clk2_eff = dev_class_i ? clk2_q : '0;

   // ---------------- PLL power-up event ----------------
   logic lock_evt;
   assign lock_evt = wr && !bus_wdata[PD_BIT] &&
                     ((at(word, W_CLK1) && clk1_q[PD_BIT]) ||
                      (at(word, W_CLK2) && dev_class_i && clk2_q[PD_BIT]));

   logic [IRQ_W-1:0] irq_raw, irq_mask;

   sysclk_irq #(.N(IRQ_W), .BIT(LOCK_BIT)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .lock_evt (lock_evt),
      .mask_we  (wr && at(word, W_MASK)),
      .clr_we   (wr && at(word, W_MISC)),
      .wdata    (bus_wdata[IRQ_W-1:0]),
      .raw_q    (irq_raw),
      .mask_q   (irq_mask),
      .irq      (irq_o)
   );

   // ---------------- divide factor ----------------
   sysclk_scale #(.SCALE_W(SCALE_W), .RST_VAL(SCALE_RST)) u_scale (
      .clk     (clk),
      .rst_n   (rst_n),
      .use2    (clk2_eff[31]),
      .fld1    (clk1_q[26:23]),
      .fld2    (clk2_eff[28:23]),
      .scale_q (clk_scale_o)
   );

   // ---------------- PLL table ----------------
   logic [31:0] pll_word;

   sysclk_pll_lut #(.TBL_OLD(TBL_OLD), .TBL_NEW(TBL_NEW)) u_lut (
      .cls  (dev_class_i),
      .idx  (clk1_q[6 +: XTAL_W]),
      .word (pll_word)
   );

   // ---------------- gating bank ----------------
   logic                   gate_hit;
   logic [SLOT_W-1:0]      gate_slot;
   logic [GATE_N-1:0][31:0] gate_q;

   assign gate_hit  = aligned && (word[WA_W-1:4] == (WA_W-4)'(W_GATE >> 4)) &&
                      (int'(word[3:2]) < GATE_GROUPS) && (int'(word[1:0]) < GATE_PER);
   assign gate_slot = SLOT_W'(word[3:2]) * SLOT_W'(GATE_PER) + SLOT_W'(word[1:0]);

   sysclk_gate_bank #(.GROUPS(GATE_GROUPS), .PER(GATE_PER)) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (bus_wen && gate_hit),
      .slot   (gate_slot),
      .wdata  (bus_wdata),
      .regs_q (gate_q)
   );

   // ---------------- read mux ----------------
   logic       id_hit;
   logic [2:0] id_idx;

   assign id_hit = aligned && (word[WA_W-1:3] == '0) && (word[2:0] != 3'd3);
   assign id_idx = (word[2:0] < 3'd3) ? word[2:0] : word[2:0] - 3'd1;

   always_comb begin
      bus_rdata = '0;
      if (id_hit)
         bus_rdata = ID_WORDS[id_idx];
      else if (gate_hit)
         bus_rdata = gate_q[gate_slot];
      else if (aligned) begin
         if (at(word, W_BOR))    bus_rdata = 32'(bor_q);
         if (at(word, W_LDO))    bus_rdata = 32'(ldo_q);
         if (at(word, W_RAW))    bus_rdata = 32'(irq_raw);
         if (at(word, W_MASK))   bus_rdata = 32'(irq_mask);
         if (at(word, W_MISC))   bus_rdata = 32'(irq_raw & irq_mask);
         if (at(word, W_RCAUSE)) bus_rdata = 32'(rcause_q);
         if (at(word, W_CLK1))   bus_rdata = clk1_q;
         if (at(word, W_PLL))    bus_rdata = pll_word;
         if (at(word, W_CLK2))   bus_rdata = clk2_eff;
      end
   end
endmodule

// File: rtl/sysclk_ctl_chk.sv
module sysclk_ctl_chk
   import sysclk_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int SCALE_W = 9
) (
   input logic               clk,
   input logic               rst_n,
   input logic               dev_class_i,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               bus_wen,
   input logic [31:0]        bus_wdata,
   input logic               irq_o,
   input logic [SCALE_W-1:0] clk_scale_o,
   input logic [31:0]        clk1_q,
   input logic [31:0]        clk2_q,
   input logic [IRQ_W-1:0]   irq_raw
);
   localparam int WA_W = ADDR_W - 2;

   logic wr_clk1, wr_clk2, wr_misc, wr_mask;
   assign wr_clk1 = bus_wen && bus_addr[1:0] == 2'b00 && bus_addr[ADDR_W-1:2] == WA_W'(W_CLK1);
   assign wr_clk2 = bus_wen && bus_addr[1:0] == 2'b00 && bus_addr[ADDR_W-1:2] == WA_W'(W_CLK2);
   assign wr_misc = bus_wen && bus_addr[1:0] == 2'b00 && bus_addr[ADDR_W-1:2] == WA_W'(W_MISC);
   assign wr_mask = bus_wen && bus_addr[1:0] == 2'b00 && bus_addr[ADDR_W-1:2] == WA_W'(W_MASK);

   // R1: power-up edge on the first clock word latches the event bit
   p_lock_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clk1 && clk1_q[PD_BIT] && !bus_wdata[PD_BIT]) |=> irq_raw[LOCK_BIT]);

   // R2: scale only moves two edges after some write
   p_scale_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(clk_scale_o) |-> $past(bus_wen, 2));

   // R4: older class never takes a write to the second clock word
   p_old_clk2_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!dev_class_i && wr_clk2) |=> $stable(clk2_q));

   // R5: clearing all status bits empties the raw status
   p_clear_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_misc && (&bus_wdata[IRQ_W-1:0])) |=> (irq_raw == '0));

   // R6: interrupt rises only after a clock-word or mask write
   p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(wr_clk1 || wr_clk2 || wr_mask));
endmodule

bind sysclk_ctl sysclk_ctl_chk #(.ADDR_W(ADDR_W), .SCALE_W(SCALE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .dev_class_i (dev_class_i),
   .bus_addr    (bus_addr),
   .bus_wen     (bus_wen),
   .bus_wdata   (bus_wdata),
   .irq_o       (irq_o),
   .clk_scale_o (clk_scale_o),
   .clk1_q      (clk1_q),
   .clk2_q      (clk2_q),
   .irq_raw     (irq_raw)
);

// File: tb/test_sysclk_ctl.sv
module test_sysclk_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dev_class_i = 1'b1;
   logic [11:0] bus_addr = '0;
   logic        bus_wen = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;
   logic [8:0]  clk_scale_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   sysclk_ctl i_sysclk_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .dev_class_i (dev_class_i),
      .bus_addr    (bus_addr),
      .bus_wen     (bus_wen),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .irq_o       (irq_o),
      .clk_scale_o (clk_scale_o)
   );

   localparam logic [31:0] CLK1_INIT = 32'h078E_3AC0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wen = 1'b0;
      #1 d = bus_rdata;
   endtask

   task automatic do_reset(input logic cls);
      @(negedge clk);
      rst_n = 1'b0; dev_class_i = cls;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic logic [31:0] tbl(input logic cls, input int i);
      return 32'hA000 + (cls ? 32'h1000 : 32'h0) + 32'(i) * 32'h11;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [31:0] prev;

      // ---------- newer class ----------
      do_reset(1'b1);
      rd(12'h060, d); chk("R10 clk1 reset", d, CLK1_INIT);
      rd(12'h070, d); chk("R4 clk2 reset new class", d, 32'h0780_2810);
      rd(12'h050, d); chk("R10 raw reset", d, 0);
      rd(12'h054, d); chk("R10 mask reset", d, 0);
      chk("R10 irq reset", 32'(irq_o), 0);
      chk("R10 scale reset", 32'(clk_scale_o), 80);

      // R3 PLL table, newer class
      for (int x = 0; x < 16; x++) begin
         wr(12'h060, (CLK1_INIT & ~32'h3C0) | (32'(x) << 6));
         rd(12'h064, d); chk("R3 pll new", d, tbl(1'b1, x));
      end

      // R2 first clock word field sweep with timing
      prev = 80;
      for (int v = 0; v < 16; v++) begin
         wr(12'h060, (CLK1_INIT & ~32'h0780_0000) | (32'(v) << 23));
         chk("R2 scale not yet", 32'(clk_scale_o), prev);
         @(negedge clk);
         chk("R2 scale clk1", 32'(clk_scale_o), 32'(5 * (v + 1)));
         prev = 32'(5 * (v + 1));
      end

      // R2 second clock word selected by bit 31
      for (int v = 0; v < 64; v++) begin
         wr(12'h070, 32'h8000_2000 | (32'(v) << 23));
         @(negedge clk);
         chk("R2 scale clk2", 32'(clk_scale_o), 32'(5 * (v + 1)));
      end
      rd(12'h050, d); chk("R1 no event while bit13 held", d, 0);
      wr(12'h070, 32'h0000_2000);
      @(negedge clk);
      chk("R2 scale back to clk1", 32'(clk_scale_o), 80);

      // R1 / R5 / R6 power-up event via clock word 1
      wr(12'h060, CLK1_INIT & ~32'h2000);
      rd(12'h050, d); chk("R1 event via clk1", d, 32'h40);
      chk("R6 irq masked off", 32'(irq_o), 0);
      rd(12'h058, d); chk("R5 masked read zero", d, 0);
      wr(12'h054, 32'hFFFF_FFFF);
      rd(12'h054, d); chk("R5 mask width", d, 32'h7F);
      chk("R6 irq on", 32'(irq_o), 1);
      rd(12'h058, d); chk("R5 masked read", d, 32'h40);
      wr(12'h050, 32'h0);
      rd(12'h050, d); chk("R7 raw write ignored", d, 32'h40);
      wr(12'h058, 32'h3F);
      rd(12'h050, d); chk("R5 clear other bits only", d, 32'h40);
      wr(12'h058, 32'h40);
      rd(12'h050, d); chk("R5 clear event", d, 0);
      chk("R6 irq off", 32'(irq_o), 0);
      wr(12'h060, CLK1_INIT & ~32'h2000);
      rd(12'h050, d); chk("R1 no event bit13 already 0", d, 0);

      // R1 via second clock word (currently bit13=1)
      wr(12'h070, 32'h0);
      rd(12'h050, d); chk("R1 event via clk2", d, 32'h40);
      chk("R6 irq via clk2", 32'(irq_o), 1);
      wr(12'h054, 32'h3F);
      chk("R6 irq masked again", 32'(irq_o), 0);
      wr(12'h058, 32'h7F);
      rd(12'h050, d); chk("R5 clear all", d, 0);

      // R7 write masks
      wr(12'h030, 32'hFFFF_FFFF); rd(12'h030, d); chk("R7 bor width", d, 32'hFFFF);
      wr(12'h034, 32'hFFFF_FFFF); rd(12'h034, d); chk("R7 ldo width", d, 32'h1F);
      wr(12'h05C, 32'hFFFF_FFFF); rd(12'h05C, d); chk("R7 reset cause width", d, 32'h3F);

      // R8 identification and holes
      for (int n = 0; n < 7; n++) begin
         rd(12'((n < 3 ? n : n + 1) * 4), d);
         chk("R8 id word", d, 32'hD1D0_0000 + 32'(n));
      end
      wr(12'h008, 32'hFFFF_FFFF);
      rd(12'h008, d); chk("R8 id write ignored", d, 32'hD1D0_0002);
      rd(12'h00C, d); chk("R8 hole 0x00C", d, 0);
      rd(12'h03C, d); chk("R8 unmapped", d, 0);
      rd(12'h062, d); chk("R8 misaligned read", d, 0);
      wr(12'h031, 32'h0);
      rd(12'h030, d); chk("R8 misaligned write ignored", d, 32'hFFFF);

      // R9 gating bank
      for (int k = 0; k < 9; k++) begin
         rd(12'(32'h100 + (k / 3) * 16 + (k % 3) * 4), d);
         chk("R9 gate reset", d, 0);
      end
      for (int k = 0; k < 9; k++)
         wr(12'(32'h100 + (k / 3) * 16 + (k % 3) * 4), 32'h5A00_00A5 ^ (32'(k) * 32'h0101_0101));
      for (int k = 0; k < 9; k++) begin
         rd(12'(32'h100 + (k / 3) * 16 + (k % 3) * 4), d);
         chk("R9 gate readback", d, 32'h5A00_00A5 ^ (32'(k) * 32'h0101_0101));
      end
      rd(12'h10C, d); chk("R8 gate hole", d, 0);

      // ---------- older class ----------
      do_reset(1'b0);
      rd(12'h070, d); chk("R4 clk2 reads 0 old class", d, 0);
      wr(12'h070, 32'h8000_0000 | (32'd3 << 23));
      rd(12'h070, d); chk("R4 clk2 write ignored", d, 0);
      @(negedge clk);
      chk("R4 scale unaffected", 32'(clk_scale_o), 80);
      rd(12'h050, d); chk("R4 no event from clk2", d, 0);
      for (int x = 0; x < 16; x++) begin
         wr(12'h060, (CLK1_INIT & ~32'h3C0) | (32'(x) << 6));
         rd(12'h064, d); chk("R3 pll old", d, tbl(1'b0, x));
      end
      wr(12'h060, CLK1_INIT & ~32'h2000);
      rd(12'h050, d); chk("R1 event old class clk1", d, 32'h40);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule